// File: doc/BRIEF.md
# Standby Mode Sequencer

This block sequences a small microcontroller into and out of its software standby modes. Software writes a 2-bit mode selection into an 8-bit mode register, either as a whole byte or one bit at a time. When a separate stop-enable bit is set and a standby request arrives, the block enters the selected mode. It drives four active-high enables that gate the oscillator, the flash memory, the PLL and the CPU/peripheral clocks.

The three modes keep different sets of units running. Each one also uses a different wake-up policy. Light idle returns at once. Deep idle and full stop first load a down-counter from a programmable stabilization-time value. The counter counts down once per clock, and the normal-mode ready flag rises only when it reaches zero. The request input typically comes from a standby instruction. The wake input comes from the interrupt logic.

Top module: `stby_seq`

## Requirements
- R1: After synchronous reset, `reg_rdata` reads 0x00, all four enables are 1 and `ready` is 1.
- R2: A byte write (`reg_we`=1, `reg_bit`=0) loads mode bits [1:0] from `reg_wdata[1:0]`. Bits 7 to 2 of `reg_rdata` always read 0. The new value is readable after the next clock edge.
- R3: A bit write (`reg_we`=1, `reg_bit`=1) loads `reg_wdata[0]` into the mode bit indexed by `reg_sel`, and leaves the other bit unchanged. A bit write with `reg_sel` 2 to 7 has no effect.
- R4: With `stp_en`=0, a standby request leaves the block in normal mode: all enables stay 1 and `ready` stays 1.
- R5: A standby request while the mode bits are 11 is ignored, and the block stays in normal mode.
- R6: Mode bits 00 select light idle. On entry, the enables are {osc,flash,pll,core} = 1110. A wake returns to normal mode at the next clock edge, with no wait.
- R7: Mode bits 10 select deep idle, with enables 1000. A wake starts a wait of N+1 cycles, where N is `stab_val`. `ready` rises N+1 edges after the edge that took the wake.
- R8: Mode bits 01 select full stop, with enables 0000. The wake wait is the same as in R7.
- R9: During the wait, the enables read 1100 and `ready` is 0. A further wake during the wait does not restart the count.
- R10: A wake in normal mode has no effect. A standby request while in a standby or wait state has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Mode register write strobe |
| reg_bit | input | 1 | 1 = single-bit write, 0 = byte write |
| reg_sel | input | 3 | Bit index for single-bit writes |
| reg_wdata | input | 8 | Write data (bit 0 used for single-bit writes) |
| reg_rdata | output | 8 | Mode register read value |
| stp_en | input | 1 | Stop-enable bit from the standby control register |
| stby_req | input | 1 | Standby request pulse |
| wake | input | 1 | Wake-up event |
| stab_val | input | CNT_W | Stabilization-time value loaded on wake |
| osc_en | output | 1 | Oscillator enable |
| flash_en | output | 1 | Flash memory enable |
| pll_en | output | 1 | PLL enable |
| core_en | output | 1 | CPU/peripheral clock enable |
| ready | output | 1 | Normal-mode ready flag |

## Verification
The bench builds the block with a 4-bit stabilization counter, so every load value from 0 to 15 is swept for both waiting modes, and each wait length is checked cycle by cycle. All 256 byte-write values and every bit index with both data values are applied to the mode register. All four mode codes are tried with the stop-enable bit clear and set. A second wake is injected in the middle of a countdown.

// File: rtl/stby_pkg.sv
package stby_pkg;

  typedef enum logic [2:0] {
    ST_NORM  = 3'd0,
    ST_LIGHT = 3'd1,
    ST_DEEP  = 3'd2,
    ST_HALT  = 3'd3,
    ST_WAIT  = 3'd4
  } stby_st_e;

  localparam logic [1:0] MSEL_LIGHT = 2'b00;
  localparam logic [1:0] MSEL_HALT  = 2'b01;
  localparam logic [1:0] MSEL_DEEP  = 2'b10;
  localparam logic [1:0] MSEL_BAD   = 2'b11;

  typedef struct packed {
    logic osc;
    logic flash;
    logic pll;
    logic core;
  } gate_t;

  function automatic gate_t gates_for(stby_st_e s);
    gate_t g;
    case (s)
      ST_LIGHT: g = '{osc: 1'b1, flash: 1'b1, pll: 1'b1, core: 1'b0};
      ST_DEEP:  g = '{osc: 1'b1, flash: 1'b0, pll: 1'b0, core: 1'b0};
      ST_HALT:  g = '{osc: 1'b0, flash: 1'b0, pll: 1'b0, core: 1'b0};
      ST_WAIT:  g = '{osc: 1'b1, flash: 1'b1, pll: 1'b0, core: 1'b0};
      default:  g = '{osc: 1'b1, flash: 1'b1, pll: 1'b1, core: 1'b1};
    endcase
    return g;
  endfunction

endpackage

// File: rtl/stby_modereg.sv
module stby_modereg #(
  parameter int REG_W  = 8,
  parameter int MODE_W = 2,
  localparam int SEL_W = $clog2(REG_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              wr_bit,
  input  logic [SEL_W-1:0]  wr_sel,
  input  logic [REG_W-1:0]  wr_data,
  output logic [MODE_W-1:0] mode,
  output logic [REG_W-1:0]  rdata
);

  for (genvar g = 0; g < MODE_W; g++) begin : g_bit
    logic hit;
    assign hit = wr_en && (!wr_bit || (wr_sel == SEL_W'(g)));
    always_ff @(posedge clk) begin
      if (rst)      mode[g] <= 1'b0;
      else if (hit) mode[g] <= wr_bit ? wr_data[0] : wr_data[g];
    end
  end

  assign rdata = {{(REG_W-MODE_W){1'b0}}, mode};

  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> $stable(mode)); // R2
  AST_RO_BITS_NOP: assert property (@(posedge clk) disable iff (rst)
    (wr_en && wr_bit && (wr_sel >= SEL_W'(MODE_W))) |=> $stable(mode)); // R3

endmodule

// File: rtl/stby_waitcnt.sv
module stby_waitcnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             run,
  output logic             zero
);

  logic [CNT_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                     cnt <= '0;
    else if (load)               cnt <= load_val;
    else if (run && cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign zero = (cnt == '0);

  AST_CNT_STEP: assert property (@(posedge clk) disable iff (rst)
    (run && !load && cnt != '0) |=> (cnt == $past(cnt) - 1'b1)); // R9

endmodule

// File: rtl/stby_fsm.sv
module stby_fsm
  import stby_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] mode,
  input  logic       stp_en,
  input  logic       req,
  input  logic       wake,
  input  logic       cnt_zero,
  output logic       cnt_load,
  output logic       cnt_run,
  output gate_t      gates,
  output logic       ready
);

  stby_st_e st, nxt;

  always_comb begin
    nxt      = st;
    cnt_load = 1'b0;
    case (st)
      ST_NORM: begin
        if (req && stp_en && mode != MSEL_BAD) begin
          case (mode)
            MSEL_LIGHT: nxt = ST_LIGHT;
            MSEL_HALT:  nxt = ST_HALT;
            default:    nxt = ST_DEEP;
          endcase
        end
      end
      ST_LIGHT: if (wake) nxt = ST_NORM;
      ST_DEEP, ST_HALT: begin
        if (wake) begin
          nxt      = ST_WAIT;
          cnt_load = 1'b1;
        end
      end
      ST_WAIT: if (cnt_zero) nxt = ST_NORM;
      default: nxt = ST_NORM;
    endcase
  end

  assign cnt_run = (st == ST_WAIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= ST_NORM;
      gates <= gates_for(ST_NORM);
      ready <= 1'b1;
    end else begin
      st    <= nxt;
      gates <= gates_for(nxt);
      ready <= (nxt == ST_NORM);
    end
  end

  AST_NO_STP_ENTRY: assert property (@(posedge clk) disable iff (rst)
    (st == ST_NORM && !stp_en) |=> (st == ST_NORM)); // R4
  AST_BAD_MODE_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (st == ST_NORM && mode == MSEL_BAD) |=> (st == ST_NORM)); // R5
  AST_LIGHT_NO_WAIT: assert property (@(posedge clk) disable iff (rst)
    (st == ST_LIGHT && wake) |=> ready); // R6
  AST_WAIT_NOT_READY: assert property (@(posedge clk) disable iff (rst)
    (st == ST_WAIT) |-> !ready); // R9
  AST_NORM_NEEDS_REQ: assert property (@(posedge clk) disable iff (rst)
    (st == ST_NORM && !req) |=> (st == ST_NORM)); // R10

endmodule

// File: rtl/stby_seq.sv
module stby_seq
  import stby_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int REG_W = 8,
  localparam int SEL_W = $clog2(REG_W)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reg_we,
  input  logic             reg_bit,
  input  logic [SEL_W-1:0] reg_sel,
  input  logic [REG_W-1:0] reg_wdata,
  output logic [REG_W-1:0] reg_rdata,
  input  logic             stp_en,
  input  logic             stby_req,
  input  logic             wake,
  input  logic [CNT_W-1:0] stab_val,
  output logic             osc_en,
  output logic             flash_en,
  output logic             pll_en,
  output logic             core_en,
  output logic             ready
);

  logic [1:0] mode;
  logic       cnt_load, cnt_run, cnt_zero;
  gate_t      gates;

  stby_modereg #(.REG_W(REG_W), .MODE_W(2)) u_reg (
    .clk(clk), .rst(rst), .wr_en(reg_we), .wr_bit(reg_bit),
    .wr_sel(reg_sel), .wr_data(reg_wdata), .mode(mode), .rdata(reg_rdata)
  );

  stby_waitcnt #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .load(cnt_load), .load_val(stab_val),
    .run(cnt_run), .zero(cnt_zero)
  );

  stby_fsm u_fsm (
    .clk(clk), .rst(rst), .mode(mode), .stp_en(stp_en), .req(stby_req),
    .wake(wake), .cnt_zero(cnt_zero), .cnt_load(cnt_load),
    .cnt_run(cnt_run), .gates(gates), .ready(ready)
  );

  assign osc_en   = gates.osc;
  assign flash_en = gates.flash;
  assign pll_en   = gates.pll;
  assign core_en  = gates.core;

  AST_READY_ALL_ON: assert property (@(posedge clk) disable iff (rst)
    ready |-> (osc_en && flash_en && pll_en && core_en)); // R1
  AST_CORE_OFF_STBY: assert property (@(posedge clk) disable iff (rst)
    !ready |-> !core_en); // R9

endmodule

// File: tb/stby_seq_tb.sv
`timescale 1ns/1ps
module stby_seq_tb;
  localparam int CW = 4;

  logic clk = 1'b0, rst = 1'b1;
  logic reg_we = 0, reg_bit = 0;
  logic [2:0] reg_sel = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic stp_en = 0, stby_req = 0, wake = 0;
  logic [CW-1:0] stab_val = 0;
  logic osc_en, flash_en, pll_en, core_en, ready;
  int n_run = 0, n_fail = 0;
  logic [7:0] model;

  always #4 clk = ~clk;

  stby_seq #(.CNT_W(CW)) u_dut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_bit(reg_bit),
    .reg_sel(reg_sel), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .stp_en(stp_en), .stby_req(stby_req), .wake(wake), .stab_val(stab_val),
    .osc_en(osc_en), .flash_en(flash_en), .pll_en(pll_en),
    .core_en(core_en), .ready(ready)
  );

  function automatic logic [4:0] obs();
    return {osc_en, flash_en, pll_en, core_en, ready};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr_byte(input logic [7:0] d);
    reg_we = 1; reg_bit = 0; reg_wdata = d;
    tick();
    reg_we = 0;
  endtask

  task automatic pulse_req();
    stby_req = 1; tick(); stby_req = 0;
  endtask

  task automatic pulse_wake();
    wake = 1; tick(); wake = 0;
  endtask

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    @(negedge clk); tick(); rst = 0; tick();
    // R1 reset state
    chk("R1 rdata", reg_rdata, 0);
    chk("R1 enables+ready", obs(), 5'b11111);

    // R2 all byte values
    for (int d = 0; d < 256; d++) begin
      wr_byte(d[7:0]);
      chk("R2 byte write", reg_rdata, d & 3);
    end

    // R3 bit writes over every index
    wr_byte(8'h00); model = 0;
    for (int s = 0; s < 8; s++) begin
      for (int v = 0; v < 2; v++) begin
        reg_we = 1; reg_bit = 1; reg_sel = s[2:0]; reg_wdata = {7'h7f, v[0]};
        tick(); reg_we = 0;
        if (s < 2) model[s] = v[0];
        chk("R3 bit write", reg_rdata, model);
      end
    end

    // R4 stop-enable clear blocks every mode
    stp_en = 0;
    for (int m = 0; m < 4; m++) begin
      wr_byte(m[7:0]); pulse_req();
      chk("R4 no stp_en", obs(), 5'b11111);
    end

    // R5 prohibited mode ignored
    stp_en = 1;
    wr_byte(8'h03); pulse_req();
    chk("R5 mode 11", obs(), 5'b11111);
    tick();
    chk("R5 mode 11 later", obs(), 5'b11111);

    // R10 wake in normal ignored
    wr_byte(8'h00); pulse_wake();
    chk("R10 wake in normal", obs(), 5'b11111);

    // R6 light idle
    pulse_req();
    chk("R6 light idle gates", obs(), 5'b11100);
    repeat (3) tick();
    chk("R6 light idle holds", obs(), 5'b11100);
    pulse_req();
    chk("R10 req in standby", obs(), 5'b11100);
    pulse_wake();
    chk("R6 immediate return", obs(), 5'b11111);

    // R7 / R8 sweep every wait length
    for (int md = 0; md < 2; md++) begin
      for (int n = 0; n < 16; n++) begin
        wr_byte(md == 0 ? 8'h02 : 8'h01);
        stab_val = n[CW-1:0];
        pulse_req();
        if (md == 0) chk("R7 deep idle gates", obs(), 5'b10000);
        else         chk("R8 stop gates", obs(), 5'b00000);
        pulse_wake();
        chk(md == 0 ? "R7 wait start" : "R8 wait start", obs(), 5'b11000);
        for (int j = 0; j < n; j++) begin
          tick();
          chk("R9 wait gates", obs(), 5'b11000);
        end
        tick();
        chk(md == 0 ? "R7 ready after N+1" : "R8 ready after N+1", obs(), 5'b11111);
      end
    end

    // R9 second wake mid-count does not restart
    wr_byte(8'h01); stab_val = 4'd6; pulse_req();
    pulse_wake();
    tick(); tick();
    wake = 1; stab_val = 4'd15; tick(); wake = 0;
    for (int j = 3; j < 6; j++) begin
      tick();
      chk("R9 no restart wait", obs(), 5'b11000);
    end
    tick();
    chk("R9 no restart ready", obs(), 5'b11111);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule